// File: doc/BRIEF.md
# Cached DRAM Row-Register Front End

This block is a synthesizable, cycle-based model of the cache front end of a DRAM that keeps one static row register per internal bank. Control pins are sampled on the rising edge of a system clock. A falling edge of the active-low row strobe starts a row cycle. In that cycle the block captures the row address, picks a bank from two of the row bits, and compares the row with the row last read into that bank. It then reports the result on an active-low hit flag. A read that misses copies the addressed row from a small behavioural array into that bank's row register. A write goes to the array and, when its row is the cached one, also updates the cached copy.

Column reads need no row cycle. The column address passes through a latch that is transparent while its active-low control is high and holds its value while the control is low. The selected byte is then read from the row register of the bank named by the last read cycle. An output latch can hold the data word. The data outputs carry a separate enable, which stands in for high impedance when it is low.

Top module: `cdram_rowcache`

## Requirements
- R1: A row cycle begins when `row_en_n` is sampled low after being sampled high with `refresh_n` high. At that edge `addr` is taken as the row, and `addr[9:8]` selects one of four banks. A strobe fall with `refresh_n` low is a refresh: it leaves `hit_n` high and changes neither the cached rows nor the data they return.
- R2: With `col_latch_n` high, the column (`addr[7:0]`) passes straight through. With `col_latch_n` low, the column is the value `addr` held at the last clock edge where `col_latch_n` was high, and it stays fixed while `col_latch_n` stays low.
- R3: A read cycle whose row differs from its bank's cached row, or whose bank holds no valid row, is a miss and loads that row into the bank's row register. The next read cycle to the same row is a hit.
- R4: `hit_n` is low only while a row cycle is active and its row matched at the strobe fall. This applies to both read and write cycles. `hit_n` returns high at the first edge where `row_en_n` is sampled high.
- R5: With no row strobe, column reads return bytes from the row register of the bank used by the most recent read cycle.
- R6: With `out_latch_en` low, `dout` follows the selected byte. While `out_latch_en` and `col_latch_n` are both high, `dout` holds the byte it showed at the edge where holding began.
- R7: A byte from `din` is written only at an edge where a write cycle is active (`wr_rd` = 1 at the strobe fall) and both `col_latch_n` and `write_en_n` are low. In every other case the write is ignored.
- R8: A write whose row is the bank's cached row also updates the row register, so later hit reads return the new byte.
- R9: `dout_en` is high only while `out_en_n` is low and the most recent row cycle was a read.
- R10: Reset clears every bank's valid bit, so the first row cycle after reset reports a miss. After reset `dout_en` is low.
- R11: Banks are independent. Filling one bank leaves the cached rows of the other banks in place, while a read miss in a bank replaces only that bank's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_en_n | input | 1 | Active-low row strobe |
| col_latch_n | input | 1 | Active-low column latch control |
| refresh_n | input | 1 | Low at strobe fall marks a refresh |
| wr_rd | input | 1 | 1 = write cycle, 0 = read cycle, taken at strobe fall |
| write_en_n | input | 1 | Active-low write data strobe |
| out_en_n | input | 1 | Active-low data output enable |
| out_latch_en | input | 1 | High lets the output latch hold |
| addr | input | 11 | Multiplexed row / column address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | High when `dout` is driven |
| hit_n | output | 1 | Active-low hit flag |

## Verification
The bench uses the default parameters: an 11-bit row, an 8-bit column, four banks at row bits 9:8, and a behavioural array of four rows by sixteen columns per bank. Rows that differ only in bits the array does not store share array cells. The bench therefore puts its test rows in distinct array slots. It also uses two rows of the same bank to cover eviction, and two rows of different banks to cover bank independence. The sixteen stored columns keep every column test within the array without aliasing.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
    localparam int ROW_W_DEF     = 11;
    localparam int COL_W_DEF     = 8;
    localparam int DATA_W_DEF    = 8;
    localparam int BANK_LSB_DEF  = 8;
    localparam int BANK_W_DEF    = 2;
    localparam int MEM_ROW_W_DEF = 2;
    localparam int MEM_COL_W_DEF = 4;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } cyc_op_e;
endpackage

// File: rtl/cdram_col_latch.sv
module cdram_col_latch #(
    parameter int COL_W = cdram_pkg::COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_latch_n,
    input  logic [COL_W-1:0] addr_col,
    output logic [COL_W-1:0] col
);
    typedef struct packed {
        logic [COL_W-1:0] held;
    } cl_state_t;

    cl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (col_latch_n) begin
            st_d.held = addr_col;
        end
        col = col_latch_n ? addr_col : st_q.held;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: on the first edge with the control low, the column equals the address seen one edge earlier
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !col_latch_n && $past(col_latch_n)) |-> (col == $past(addr_col)));

    // R2: the column stays fixed while the control stays low
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !col_latch_n && !$past(col_latch_n)) |-> $stable(col));
endmodule

// File: rtl/cdram_tag_bank.sv
module cdram_tag_bank #(
    parameter int ROW_W    = cdram_pkg::ROW_W_DEF,
    parameter int BANK_LSB = cdram_pkg::BANK_LSB_DEF,
    parameter int BANK_W   = cdram_pkg::BANK_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] look_row,
    input  logic             fill_en,
    output logic             look_hit
);
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic [NBANK-1:0]            valid;
        logic [NBANK-1:0][ROW_W-1:0] tag;
    } tag_state_t;

    tag_state_t        st_d, st_q;
    logic [BANK_W-1:0] look_bank;

    always_comb begin
        look_bank = look_row[BANK_LSB +: BANK_W];
        look_hit  = st_q.valid[look_bank] && (st_q.tag[look_bank] == look_row);
        st_d      = st_q;
        if (fill_en) begin
            st_d.valid[look_bank] = 1'b1;
            st_d.tag[look_bank]   = look_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: after a fill, the bank holds the filled row as a valid entry
    p_fill_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.valid[$past(look_bank)] && (st_q.tag[$past(look_bank)] == $past(look_row))));

    // R11: a fill touches only the bank it addresses
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
            p_bank_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (fill_en && (look_bank != BANK_W'(b))) |=> ($stable(st_q.tag[b]) && $stable(st_q.valid[b])));
        end
    endgenerate
endmodule

// File: rtl/cdram_row_store.sv
module cdram_row_store #(
    parameter int ROW_W     = cdram_pkg::ROW_W_DEF,
    parameter int COL_W     = cdram_pkg::COL_W_DEF,
    parameter int DATA_W    = cdram_pkg::DATA_W_DEF,
    parameter int BANK_W    = cdram_pkg::BANK_W_DEF,
    parameter int MEM_ROW_W = cdram_pkg::MEM_ROW_W_DEF,
    parameter int MEM_COL_W = cdram_pkg::MEM_COL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [BANK_W-1:0] fill_bank,
    input  logic [ROW_W-1:0]  fill_row,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_cached,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NBANK     = 1 << BANK_W;
    localparam int NROW      = 1 << MEM_ROW_W;
    localparam int NCOL      = 1 << MEM_COL_W;
    localparam int MEM_DEPTH = NBANK * NROW * NCOL;
    localparam int IDX_W     = BANK_W + MEM_ROW_W + MEM_COL_W;

    typedef struct packed {
        logic [MEM_DEPTH-1:0][DATA_W-1:0]         cells;
        logic [NBANK-1:0][NCOL-1:0][DATA_W-1:0]   line;
    } store_t;

    store_t               st_d, st_q;
    logic [IDX_W-1:0]     wr_idx;
    logic [MEM_COL_W-1:0] wr_slot;
    logic [MEM_COL_W-1:0] rd_slot;
    logic [IDX_W-1:0]     fill_base;

    function automatic logic [MEM_COL_W-1:0] col_slot(input logic [COL_W-1:0] c);
        return MEM_COL_W'(int'(c) % NCOL);
    endfunction

    function automatic logic [IDX_W-1:0] row_base(input logic [BANK_W-1:0] b,
                                                  input logic [ROW_W-1:0]  r);
        return IDX_W'((int'(b) * NROW + (int'(r) % NROW)) * NCOL);
    endfunction

    always_comb begin
        st_d      = st_q;
        wr_slot   = col_slot(wr_col);
        rd_slot   = col_slot(rd_col);
        wr_idx    = row_base(wr_bank, wr_row) + IDX_W'(wr_slot);
        fill_base = row_base(fill_bank, fill_row);

        if (fill_en) begin
            for (int c = 0; c < NCOL; c++) begin
                st_d.line[fill_bank][MEM_COL_W'(c)] = st_q.cells[fill_base + IDX_W'(c)];
            end
        end

        if (wr_en) begin
            st_d.cells[wr_idx] = wr_data;
            if (wr_cached) begin
                st_d.line[wr_bank][wr_slot] = wr_data;
            end
        end

        rd_data = st_q.line[rd_bank][rd_slot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an accepted write lands in the array cell it addresses
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.cells[$past(wr_idx)] == $past(wr_data)));

    // R8: a write to the cached row reaches the row register too
    p_cache_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cached) |=> (st_q.line[$past(wr_bank)][$past(wr_slot)] == $past(wr_data)));

    // R7: with no write and no fill, the array and row registers do not change
    p_quiet_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !$past(fill_en)) |-> $stable(st_q));
endmodule

// File: rtl/cdram_out_latch.sv
module cdram_out_latch #(
    parameter int DATA_W = cdram_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_latch_n,
    input  logic              out_latch_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] kept;
    } ol_state_t;

    ol_state_t st_d, st_q;
    logic      holding;

    always_comb begin
        holding = out_latch_en && col_latch_n;
        st_d    = st_q;
        if (!holding) begin
            st_d.kept = rd_data;
        end
        dout = holding ? st_q.kept : rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the output does not move while the hold condition persists
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && holding && $past(holding)) |-> $stable(dout));

    // R6: a transparent latch shows the selected byte
    p_out_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_latch_en |-> (dout == rd_data));
endmodule

// File: rtl/cdram_rowcache.sv
module cdram_rowcache #(
    parameter int ROW_W     = cdram_pkg::ROW_W_DEF,
    parameter int COL_W     = cdram_pkg::COL_W_DEF,
    parameter int DATA_W    = cdram_pkg::DATA_W_DEF,
    parameter int BANK_LSB  = cdram_pkg::BANK_LSB_DEF,
    parameter int BANK_W    = cdram_pkg::BANK_W_DEF,
    parameter int MEM_ROW_W = cdram_pkg::MEM_ROW_W_DEF,
    parameter int MEM_COL_W = cdram_pkg::MEM_COL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_en_n,
    input  logic              col_latch_n,
    input  logic              refresh_n,
    input  logic              wr_rd,
    input  logic              write_en_n,
    input  logic              out_en_n,
    input  logic              out_latch_en,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              hit_n
);
    import cdram_pkg::*;

    typedef struct packed {
        logic              strobe_prev;
        logic              active;
        logic              matched;
        cyc_op_e           op;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              read_mode;
        logic [BANK_W-1:0] read_bank;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              strobe_fall;
    logic              row_cycle;
    logic [BANK_W-1:0] addr_bank;
    logic              tag_hit;
    logic              fill_en;
    logic              wr_fire;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        strobe_fall = !row_en_n && ctl_q.strobe_prev;
        row_cycle   = strobe_fall && refresh_n;
        addr_bank   = addr[BANK_LSB +: BANK_W];
        fill_en     = row_cycle && !wr_rd && !tag_hit;
        wr_fire     = ctl_q.active && (ctl_q.op == OP_WRITE) && !col_latch_n && !write_en_n;

        ctl_d             = ctl_q;
        ctl_d.strobe_prev = row_en_n;
        if (row_en_n) begin
            ctl_d.active = 1'b0;
        end
        if (row_cycle) begin
            ctl_d.active  = 1'b1;
            ctl_d.matched = tag_hit;
            ctl_d.op      = wr_rd ? OP_WRITE : OP_READ;
            ctl_d.bank    = addr_bank;
            ctl_d.row     = addr;
            if (wr_rd) begin
                ctl_d.read_mode = 1'b0;
            end else begin
                ctl_d.read_mode = 1'b1;
                ctl_d.read_bank = addr_bank;
            end
        end

        hit_n   = !(ctl_q.active && ctl_q.matched);
        dout_en = !out_en_n && ctl_q.read_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q             <= '0;
            ctl_q.strobe_prev <= 1'b1;
            ctl_q.op          <= OP_READ;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cdram_col_latch #(
        .COL_W (COL_W)
    ) u_col_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_latch_n (col_latch_n),
        .addr_col    (addr[COL_W-1:0]),
        .col         (col)
    );

    cdram_tag_bank #(
        .ROW_W    (ROW_W),
        .BANK_LSB (BANK_LSB),
        .BANK_W   (BANK_W)
    ) u_tag_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_row (addr),
        .fill_en  (fill_en),
        .look_hit (tag_hit)
    );

    cdram_row_store #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W),
        .MEM_ROW_W (MEM_ROW_W),
        .MEM_COL_W (MEM_COL_W)
    ) u_row_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_bank (addr_bank),
        .fill_row  (addr),
        .wr_en     (wr_fire),
        .wr_bank   (ctl_q.bank),
        .wr_row    (ctl_q.row),
        .wr_col    (col),
        .wr_data   (din),
        .wr_cached (ctl_q.matched),
        .rd_bank   (ctl_q.read_bank),
        .rd_col    (col),
        .rd_data   (rd_data)
    );

    cdram_out_latch #(
        .DATA_W (DATA_W)
    ) u_out_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .col_latch_n  (col_latch_n),
        .out_latch_en (out_latch_en),
        .rd_data      (rd_data),
        .dout         (dout)
    );

    // R4: a low hit flag implies the strobe was low at the previous edge
    p_hit_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_n |-> $past(!row_en_n));

    // R1: a refresh strobe never shows a hit
    p_refresh_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fall && !refresh_n) |=> hit_n);

    // R9: outputs are enabled only after a read cycle began
    p_read_only_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (row_cycle && wr_rd) |=> !dout_en);
endmodule

// File: tb/cdram_rowcache_tb.sv
`timescale 1ns/1ps
module cdram_rowcache_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_en_n = 1'b1;
    logic       col_latch_n = 1'b1;
    logic       refresh_n = 1'b1;
    logic       wr_rd = 1'b0;
    logic       write_en_n = 1'b1;
    logic       out_en_n = 1'b1;
    logic       out_latch_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;
    logic       hit_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cdram_rowcache u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_en_n     (row_en_n),
        .col_latch_n  (col_latch_n),
        .refresh_n    (refresh_n),
        .wr_rd        (wr_rd),
        .write_en_n   (write_en_n),
        .out_en_n     (out_en_n),
        .out_latch_en (out_latch_en),
        .addr         (addr),
        .din          (din),
        .dout         (dout),
        .dout_en      (dout_en),
        .hit_n        (hit_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic open_row(input logic [10:0] row, input logic is_write);
        addr = row;
        wr_rd = is_write;
        row_en_n = 1'b0;
        tick();
    endtask

    task automatic close_row();
        row_en_n = 1'b1;
        wr_rd = 1'b0;
        tick();
    endtask

    task automatic write_col(input logic [10:0] c, input logic [7:0] d);
        col_latch_n = 1'b1;
        addr = c;
        tick();
        col_latch_n = 1'b0;
        write_en_n = 1'b0;
        din = d;
        tick();
        write_en_n = 1'b1;
        col_latch_n = 1'b1;
    endtask

    task automatic read_col(input logic [10:0] c, input logic [7:0] exp, input string req);
        col_latch_n = 1'b1;
        addr = c;
        settle();
        check(req, "column read", dout, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R10", "hit_n after reset", {7'd0, hit_n}, 8'd1);
        check("R10", "dout_en after reset", {7'd0, dout_en}, 8'd0);
    endtask

    task automatic t_write_fill();
        open_row(11'h005, 1'b1);
        check("R10", "first cycle misses", {7'd0, hit_n}, 8'd1);
        write_col(11'd3, 8'hA5);
        write_col(11'd9, 8'h3C);
        // R7: write strobe low with latch control high: ignored
        col_latch_n = 1'b1;
        addr = 11'd3;
        din = 8'hFF;
        write_en_n = 1'b0;
        tick();
        tick();
        write_en_n = 1'b1;
        close_row();
        // R7: write strobes outside any row cycle: ignored
        write_col(11'd9, 8'hEE);
    endtask

    task automatic t_read_miss();
        open_row(11'h005, 1'b0);
        check("R3", "read miss flag", {7'd0, hit_n}, 8'd1);
        close_row();
        out_en_n = 1'b0;
        settle();
        check("R9", "dout_en after read", {7'd0, dout_en}, 8'd1);
        read_col(11'd3, 8'hA5, "R5");
        read_col(11'd9, 8'h3C, "R7");
    endtask

    task automatic t_read_hit();
        open_row(11'h005, 1'b0);
        check("R3", "repeat read hits", {7'd0, hit_n}, 8'd0);
        close_row();
        check("R4", "hit_n after strobe rise", {7'd0, hit_n}, 8'd1);
    endtask

    task automatic t_refresh();
        refresh_n = 1'b0;
        open_row(11'h006, 1'b0);
        check("R1", "refresh shows no hit", {7'd0, hit_n}, 8'd1);
        close_row();
        refresh_n = 1'b1;
        read_col(11'd9, 8'h3C, "R1");
    endtask

    task automatic t_col_latch();
        col_latch_n = 1'b1;
        addr = 11'd3;
        tick();
        col_latch_n = 1'b0;
        addr = 11'd9;
        settle();
        check("R2", "captured column", dout, 8'hA5);
        tick();
        check("R2", "column held", dout, 8'hA5);
        col_latch_n = 1'b1;
        settle();
        check("R2", "transparent column", dout, 8'h3C);
    endtask

    task automatic t_out_latch();
        out_latch_en = 1'b0;
        col_latch_n = 1'b1;
        addr = 11'd3;
        tick();
        check("R6", "transparent output", dout, 8'hA5);
        out_latch_en = 1'b1;
        addr = 11'd9;
        settle();
        check("R6", "output held", dout, 8'hA5);
        tick();
        check("R6", "output still held", dout, 8'hA5);
        col_latch_n = 1'b0;
        settle();
        check("R6", "hold released", dout, 8'h3C);
        col_latch_n = 1'b1;
        out_latch_en = 1'b0;
    endtask

    task automatic t_write_hit();
        open_row(11'h005, 1'b1);
        check("R4", "write hit flag", {7'd0, hit_n}, 8'd0);
        check("R9", "no drive in write cycle", {7'd0, dout_en}, 8'd0);
        write_col(11'd3, 8'h77);
        close_row();
        open_row(11'h005, 1'b0);
        check("R8", "row still cached", {7'd0, hit_n}, 8'd0);
        close_row();
        read_col(11'd3, 8'h77, "R8");
    endtask

    task automatic t_banks();
        open_row(11'h105, 1'b1);
        check("R1", "other bank write misses", {7'd0, hit_n}, 8'd1);
        write_col(11'd3, 8'h42);
        close_row();
        open_row(11'h105, 1'b0);
        check("R1", "other bank read misses", {7'd0, hit_n}, 8'd1);
        close_row();
        read_col(11'd3, 8'h42, "R1");
        open_row(11'h005, 1'b0);
        check("R11", "bank 0 kept", {7'd0, hit_n}, 8'd0);
        close_row();
        read_col(11'd3, 8'h77, "R11");
        open_row(11'h006, 1'b0);
        check("R11", "new row in bank 0 misses", {7'd0, hit_n}, 8'd1);
        close_row();
        read_col(11'd3, 8'h00, "R11");
        open_row(11'h005, 1'b0);
        check("R3", "evicted row misses", {7'd0, hit_n}, 8'd1);
        close_row();
        read_col(11'd3, 8'h77, "R3");
    endtask

    task automatic t_output_enable();
        out_en_n = 1'b1;
        settle();
        check("R9", "disabled output", {7'd0, dout_en}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_write_fill();
        t_read_miss();
        t_read_hit();
        t_refresh();
        t_col_latch();
        t_out_latch();
        t_write_hit();
        t_banks();
        t_output_enable();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule